// File: doc/BRIEF.md
# E-link Packet Framer with Length Guard

This block sits behind the byte recovery of one E-link channel. It takes the incoming byte stream with its start and end markers and cuts it into packets for routing further on. Every framed packet begins with a one-byte stream identifier. In length mode, a two-byte payload length follows the identifier. The identifier is carried beside each payload byte on the output, and a three-bit status word comes out together with the final byte of each packet.

Three boundary modes are selectable. In marker mode, a start marker opens a packet and an end marker closes it. In length mode, the length from the header closes the packet. In raw mode, the bytes pass through with no framing at all. A nonzero maximum length cuts off oversize packets: the excess bytes are dropped and the packet is flagged as truncated. An optional modulo-256 checksum test compares the last payload byte with the sum of the payload bytes before it. The mode, the maximum length and the checksum enable are sampled only while no packet is in progress.

Top module: `elink_pkt_framer`

## Requirements
- R1: Marker mode (cfg_mode=0): a valid byte with in_sop set and in_eop clear opens a packet and is taken as its stream identifier without being output. The following valid bytes, up to and including the byte with in_eop set, are the payload. Payload bytes leave in order, with out_first on the first one and out_last on the final one.
- R2: In marker mode, valid bytes that arrive outside a packet without in_sop are discarded. A start byte that also carries in_eop discards the whole packet, so no output results.
- R3: Length mode (cfg_mode=1): the first valid byte while idle is the stream identifier. The next two bytes give the payload length, high byte first. Exactly that many following bytes form the payload and in_sop is ignored. A declared length of 0, or in_eop on a header byte, discards the packet.
- R4: In length mode, in_eop on a payload byte before the declared count is reached closes the packet at that byte and sets status bit 1 (short).
- R5: With cfg_maxlen nonzero, only the first cfg_maxlen payload bytes are output and the rest are dropped. Status bit 0 (truncated) is then set, and the last kept byte still carries out_last. A cfg_maxlen of 0 means no limit.
- R6: With cfg_csum_en set, status bit 2 is set when the final received payload byte differs from the modulo-256 sum of all earlier received payload bytes. With cfg_csum_en clear, bit 2 stays 0.
- R7: out_stat_valid is high only together with out_last, and out_status is 0 on every other output byte.
- R8: out_sid presents all 8 bits of the packet's identifier byte unchanged with every payload byte, including any trigger-derived extension bits.
- R9: Raw mode (cfg_mode=2 or 3): every valid byte appears on out_data one cycle later with out_valid set and out_first, out_last, out_stat_valid, out_sid and out_status all 0. The markers are ignored.
- R10: Configuration changes made while a packet is in progress do not affect that packet. They take effect from the next packet.
- R11: While reset is asserted and right after it, out_valid, out_first, out_last and out_stat_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | Start marker on this byte |
| in_eop | input | 1 | End marker on this byte |
| cfg_mode | input | 2 | 0 markers, 1 header length, 2/3 raw |
| cfg_maxlen | input | 16 | Payload byte limit, 0 for none |
| cfg_csum_en | input | 1 | Enable checksum test |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Output payload byte |
| out_first | output | 1 | First payload byte of a packet |
| out_last | output | 1 | Final payload byte of a packet |
| out_sid | output | 8 | Stream identifier of the packet |
| out_stat_valid | output | 1 | Status word valid |
| out_status | output | 3 | {checksum error, short, truncated} |

## Verification
The block has no parameters, so the bench always builds it with its fixed 8-bit data and 16-bit length fields. It drives cfg_maxlen with small values from 1 to 8 against payloads of up to 12 bytes. These small values make truncation reachable often, including the exact-fit case and the case where a single byte is kept. Declared lengths a few bytes above the bytes actually sent produce short packets, and checksum bytes are either made to match or left random. Mid-packet changes to the configuration and a raw-mode stream round out the directed cases.

// File: rtl/elink_pkt_framer.sv
module elink_pkt_framer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_sop,
  input  logic       in_eop,
  input  logic [1:0] cfg_mode,
  input  logic [15:0] cfg_maxlen,
  input  logic       cfg_csum_en,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_first,
  output logic       out_last,
  output logic [7:0] out_sid,
  output logic       out_stat_valid,
  output logic [2:0] out_status
);
  localparam logic [1:0] MODE_MARK = 2'd0;
  localparam logic [1:0] MODE_LEN  = 2'd1;

  typedef enum logic [1:0] {S_IDLE, S_LHI, S_LLO, S_BODY} st_t;

  st_t         st_q;
  logic [1:0]  mode_q;
  logic [15:0] mlen_q, len_q, cnt_q;
  logic        cken_q;
  logic [7:0]  sid_q, sum_q, held_q;
  logic        hv_q, hfirst_q, fin_q;
  logic        trunc_q, short_q, ckerr_q;

  logic idle, keep, len_end, end_b;
  logic [1:0] mode;

  assign idle    = (st_q == S_IDLE) && !fin_q;
  assign mode    = idle ? cfg_mode : mode_q;
  assign keep    = (mlen_q == 16'd0) || (cnt_q < mlen_q);
  assign len_end = (mode_q == MODE_LEN) && (cnt_q == len_q - 16'd1);
  assign end_b   = in_valid && (st_q == S_BODY) && (in_eop || len_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      mode_q <= MODE_MARK;
      mlen_q <= '0;
      cken_q <= 1'b0;
      len_q <= '0;
      cnt_q <= '0;
      sid_q <= '0;
      sum_q <= '0;
      held_q <= '0;
      hv_q <= 1'b0;
      hfirst_q <= 1'b0;
      fin_q <= 1'b0;
      trunc_q <= 1'b0;
      short_q <= 1'b0;
      ckerr_q <= 1'b0;
      out_valid <= 1'b0;
      out_data <= '0;
      out_first <= 1'b0;
      out_last <= 1'b0;
      out_sid <= '0;
      out_stat_valid <= 1'b0;
      out_status <= '0;
    end else begin
      out_valid <= 1'b0;
      out_first <= 1'b0;
      out_last <= 1'b0;
      out_stat_valid <= 1'b0;
      out_status <= '0;

      if (idle) begin
        mode_q <= cfg_mode;
        mlen_q <= cfg_maxlen;
        cken_q <= cfg_csum_en;
      end

      if (fin_q) begin
        out_valid <= 1'b1;
        out_data <= held_q;
        out_first <= hfirst_q;
        out_last <= 1'b1;
        out_sid <= sid_q;
        out_stat_valid <= 1'b1;
        out_status <= {ckerr_q, short_q, trunc_q};
        fin_q <= 1'b0;
        hv_q <= 1'b0;
      end

      case (st_q)
        S_IDLE: if (in_valid) begin
          if (mode[1]) begin
            out_valid <= 1'b1;
            out_data <= in_data;
            out_sid <= '0;
          end else if ((mode == MODE_MARK) ? (in_sop && !in_eop) : !in_eop) begin
            sid_q <= in_data;
            cnt_q <= '0;
            sum_q <= '0;
            trunc_q <= 1'b0;
            short_q <= 1'b0;
            ckerr_q <= 1'b0;
            st_q <= (mode == MODE_MARK) ? S_BODY : S_LHI;
          end
        end
        S_LHI: if (in_valid) begin
          len_q[15:8] <= in_data;
          st_q <= in_eop ? S_IDLE : S_LLO;
        end
        S_LLO: if (in_valid) begin
          len_q[7:0] <= in_data;
          st_q <= (in_eop || {len_q[15:8], in_data} == 16'd0) ? S_IDLE : S_BODY;
        end
        S_BODY: if (in_valid) begin
          cnt_q <= (&cnt_q) ? cnt_q : cnt_q + 16'd1;
          sum_q <= sum_q + in_data;
          if (keep) begin
            if (hv_q) begin
              out_valid <= 1'b1;
              out_data <= held_q;
              out_first <= hfirst_q;
              out_sid <= sid_q;
            end
            held_q <= in_data;
            hv_q <= 1'b1;
            hfirst_q <= !hv_q;
          end else begin
            trunc_q <= 1'b1;
          end
          if (end_b) begin
            st_q <= S_IDLE;
            fin_q <= 1'b1;
            short_q <= (mode_q == MODE_LEN) && !len_end;
            ckerr_q <= cken_q && (sum_q != in_data);
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R9
  raw_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && cfg_mode[1] && in_valid) |=>
      (out_valid && out_data == $past(in_data) && !out_first && !out_last && !out_stat_valid));

  // R2
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !in_valid) |=> !out_valid);

  // R7
  stat_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_stat_valid |-> (out_valid && out_last));

  // R5
  trunc_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_stat_valid && out_status[0]) |-> (mlen_q != 16'd0));

  // R4
  short_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_stat_valid && out_status[1]) |-> (mode_q == MODE_LEN));

  // R6
  csum_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_stat_valid && out_status[2]) |-> cken_q);

  // R1
  first_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_first) |-> !mode_q[1]);
endmodule

// File: tb/tb_elink_pkt_framer.sv
module tb_elink_pkt_framer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, cfg_csum_en = 1'b0;
  logic [7:0] in_data = '0;
  logic [1:0] cfg_mode = 2'd0;
  logic [15:0] cfg_maxlen = '0;
  logic out_valid, out_first, out_last, out_stat_valid;
  logic [7:0] out_data, out_sid;
  logic [2:0] out_status;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [21:0] exp_q[$];
  string tag_q[$];
  logic [7:0] pl [0:63];

  always #4 clk = ~clk;

  elink_pkt_framer dut (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      logic [21:0] got;
      got = {out_first, out_last, out_stat_valid, out_status, out_sid, out_data};
      if (exp_q.size() == 0) check(0, "R2 unexpected output", {10'd0, got}, 32'd0);
      else begin
        logic [21:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(got == e, t, {10'd0, got}, {10'd0, e});
      end
    end
  end

  task automatic put(input logic [7:0] d, input logic s, input logic e);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
  endtask

  task automatic gap(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    end
  endtask

  function automatic logic [7:0] sum_pre(input int n);
    logic [7:0] s = '0;
    for (int i = 0; i < n - 1; i++) s = s + pl[i];
    return s;
  endfunction

  function automatic void expect_pkt(input logic [7:0] sid, input int n, input int mlen,
                                     input bit ck, input bit shrt, input string tag);
    int kept;
    logic tr, ce;
    kept = (mlen == 0 || n < mlen) ? n : mlen;
    tr = (kept < n);
    ce = ck && (sum_pre(n) != pl[n-1]);
    for (int i = 0; i < kept; i++) begin
      logic lst;
      lst = (i == kept - 1);
      exp_q.push_back({(i == 0), lst, lst, lst ? {ce, shrt, tr} : 3'b000, sid, pl[i]});
      tag_q.push_back(tag);
    end
  endfunction

  task automatic send_mark(input logic [7:0] sid, input int n, input string tag);
    expect_pkt(sid, n, cfg_maxlen, cfg_csum_en, 1'b0, tag);
    put(sid, 1'b1, 1'b0);
    for (int i = 0; i < n; i++) put(pl[i], 1'b0, i == n - 1);
    gap(1);
  endtask

  task automatic send_len(input logic [7:0] sid, input logic [15:0] len, input int n, input string tag);
    if (len != 0) expect_pkt(sid, n, cfg_maxlen, cfg_csum_en, (n < len), tag);
    put(sid, 1'b0, 1'b0);
    put(len[15:8], 1'b0, 1'b0);
    put(len[7:0], 1'b0, 1'b0);
    if (len != 0)
      for (int i = 0; i < n; i++) put(pl[i], 1'b1, (n < len) && (i == n - 1));
    gap(1);
  endtask

  task automatic drained(input string tag);
    gap(4);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  task automatic cfg(input logic [1:0] m, input logic [15:0] ml, input bit ck);
    @(negedge clk);
    in_valid = 1'b0;
    cfg_mode = m; cfg_maxlen = ml; cfg_csum_en = ck;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!out_valid && !out_first && !out_last && !out_stat_valid, "R11 in reset",
          {out_valid, out_first, out_last, out_stat_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !out_stat_valid, "R11 after reset", {out_valid, out_stat_valid}, 0);

    // R1 R8 basic marker packet, identifier with extension bits set
    cfg(2'd0, 16'd0, 1'b0);
    for (int i = 0; i < 4; i++) pl[i] = 8'h10 + 8'(i);
    send_mark(8'hA5, 4, "R1/R8 marker basic");
    for (int i = 0; i < 1; i++) pl[i] = 8'h77;
    send_mark(8'hF3, 1, "R1/R7 single byte");
    drained("R1 marker drained");

    // R2 stray bytes and start+end header
    put(8'h11, 1'b0, 1'b0); put(8'h22, 1'b0, 1'b1); put(8'h33, 1'b1, 1'b1);
    gap(1);
    drained("R2 stray discarded");

    // R3 length mode exact and zero length
    cfg(2'd1, 16'd0, 1'b0);
    for (int i = 0; i < 5; i++) pl[i] = 8'h40 + 8'(i);
    send_len(8'h3C, 16'd5, 5, "R3 length exact");
    send_len(8'h3D, 16'd0, 0, "R3 zero length");
    drained("R3 length drained");

    // R4 short packet
    send_len(8'h81, 16'd6, 3, "R4 short");
    drained("R4 drained");

    // R5 truncation: over, exact fit, single kept, length mode
    cfg(2'd0, 16'd3, 1'b0);
    for (int i = 0; i < 7; i++) pl[i] = 8'hC0 + 8'(i);
    send_mark(8'h05, 7, "R5 truncate marker");
    send_mark(8'h06, 3, "R5 exact fit");
    cfg(2'd0, 16'd1, 1'b0);
    send_mark(8'h07, 4, "R5 keep one");
    cfg(2'd1, 16'd2, 1'b0);
    send_len(8'h08, 16'd5, 5, "R5 truncate length");
    drained("R5 drained");

    // R6 checksum good, bad, disabled
    cfg(2'd0, 16'd0, 1'b1);
    pl[0] = 8'hF0; pl[1] = 8'h20; pl[2] = 8'h10;
    send_mark(8'h61, 3, "R6 csum good");
    pl[2] = 8'h11;
    send_mark(8'h62, 3, "R6 csum bad");
    cfg(2'd0, 16'd0, 1'b0);
    send_mark(8'h63, 3, "R6 csum off");
    drained("R6 drained");

    // R10 configuration changed mid-packet
    cfg(2'd0, 16'd0, 1'b0);
    for (int i = 0; i < 6; i++) pl[i] = 8'h90 + 8'(i);
    expect_pkt(8'h2A, 6, 0, 1'b0, 1'b0, "R10 mid-packet change ignored");
    put(8'h2A, 1'b1, 1'b0);
    put(pl[0], 1'b0, 1'b0); put(pl[1], 1'b0, 1'b0);
    cfg_maxlen = 16'd2; cfg_csum_en = 1'b1; cfg_mode = 2'd1;
    for (int i = 2; i < 6; i++) put(pl[i], 1'b0, i == 5);
    gap(1);
    cfg(2'd0, 16'd2, 1'b1);
    send_mark(8'h2B, 5, "R10 new config applied");
    drained("R10 drained");

    // R9 raw stream with markers
    cfg(2'd2, 16'd1, 1'b1);
    for (int i = 0; i < 10; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      exp_q.push_back({6'd0, 8'd0, d});
      tag_q.push_back("R9 raw pass");
      put(d, 1'($urandom), 1'($urandom));
    end
    gap(1);
    drained("R9 drained");

    // random packets in both framed modes
    for (int p = 0; p < 60; p++) begin
      int n, ml;
      bit ck, lm;
      logic [7:0] sid;
      lm = 1'($urandom);
      ml = ($urandom % 3 == 0) ? 0 : 1 + int'($urandom % 8);
      ck = 1'($urandom);
      cfg({1'b0, lm}, 16'(ml), ck);
      n = 1 + int'($urandom % 12);
      for (int i = 0; i < n; i++) pl[i] = 8'($urandom);
      if ($urandom % 2 == 0) pl[n-1] = sum_pre(n);
      sid = 8'($urandom);
      if (lm) send_len(sid, 16'(n + (($urandom % 2 == 0) ? 0 : 1 + int'($urandom % 3))), n, "R3/R4/R5/R6 random length");
      else send_mark(sid, n, "R1/R5/R6 random marker");
      gap(int'($urandom % 2));
    end
    drained("R1 random drained");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule